// File: doc/BRIEF.md
# Addressed Scan Acknowledge Transmitter

This block sends the answer frame on the serial scan data line when the port has been selected. The address receiver elsewhere compares the incoming select address with the local one. When they are equal it raises a one-cycle match pulse. This block then replies with the local address, so the bus master can see which port took the selection. If no match pulse arrives, the block sends nothing and the output line stays at the idle level.

Every frame element is a two-bit token, and the high bit of each token goes out first. The reply is a select token, then one data token per address bit with bit 0 first, then a second select token, then a closing idle token. The idle level already on the line before the match serves as the leading idle token. The first select bit appears in the cycle right after the match pulse is sampled, with no delay tokens inserted. After that, each pulse on the bit strobe moves the line on by one serial bit. The address is captured together with the match pulse. The busy flag marks the whole reply, and a match pulse that arrives during a reply is dropped.

Top module: `ack_tx`

## Requirements
- R1: After the asynchronous active-low reset, busy_o is 0 and tdo_o is 1.
- R2: While no frame is in progress, tdo_o stays 1 and busy_o stays 0, whatever bit_stb_i does.
- R3: When match_i is sampled high while busy_o is 0, busy_o is 1 and tdo_o is 0 after that same clock edge, with no strobe needed. This is the high bit of the opening select token.
- R4: The token codes, high bit first, are: select 00, data-one 10, data-zero 01, idle 11. Each clock with bit_stb_i high during a frame moves tdo_o on by exactly one serial bit.
- R5: A frame is 26 serial bits. In order they are: select, ADDR_W=10 data tokens, select, idle.
- R6: Data token k (k = 0 first) carries address bit k. It is data-one when the bit is 1 and data-zero when the bit is 0.
- R7: The address sent is the addr_i value sampled together with the accepted match pulse. Changes on addr_i during the frame do not alter it.
- R8: busy_o stays 1 from the opening select bit through the last bit of the closing idle token. It falls on the strobe that ends that bit, and tdo_o is then 1.
- R9: A match_i pulse while busy_o is 1 does not change the frame in progress and does not start another frame after it.
- R10: During a frame, cycles without bit_stb_i leave tdo_o and busy_o unchanged.
- R11: A match_i pulse in the cycle after busy_o falls starts a new frame, following R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| match_i | input | 1 | One-cycle pulse: the select address matched |
| addr_i | input | 10 | Local port address |
| bit_stb_i | input | 1 | Serial bit strobe; moves the frame on by one bit |
| tdo_o | output | 1 | Serial scan data out |
| busy_o | output | 1 | High while an acknowledge frame is being sent |

## Verification
A fault in the token counter or the half-token flag shows up on tdo_o within one strobe. It appears as a repeated or skipped bit, or as a data token in the wrong slot, and the bench checks every one of the 26 bits against a stream it builds itself. A fault in the address capture appears at the first data token after addr_i changes in the middle of a frame. A fault in the busy logic shows up at the ports in one of three ways: the flag drops early, a second frame starts, or the line stays low after the 26th strobe.

// File: rtl/ack_pkg.sv
package ack_pkg;
  typedef logic [1:0] sym_t;

  localparam sym_t SYM_IDLE   = 2'b11;
  localparam sym_t SYM_SELECT = 2'b00;
  localparam sym_t SYM_ONE    = 2'b10;
  localparam sym_t SYM_ZERO   = 2'b01;

  typedef enum logic [1:0] {
    TK_SELECT,
    TK_DATA,
    TK_IDLE
  } tok_kind_e;
endpackage

// File: rtl/ack_addr_latch.sv
module ack_addr_latch #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= addr_i;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/ack_seq_ctrl.sv
module ack_seq_ctrl #(
  parameter int ADDR_W   = 10,
  parameter int TOK_W    = $clog2(ADDR_W + 3),
  localparam int LAST_TOK = ADDR_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             match_i,
  input  logic             stb_i,
  output logic             load_o,
  output logic             busy_o,
  output logic [TOK_W-1:0] tok_o,
  output logic             half_o
);
  logic             busy_q;
  logic [TOK_W-1:0] tok_q;
  logic             half_q;
  logic             start;
  logic             last_bit;

  assign start    = match_i && !busy_q;
  assign last_bit = half_q && (tok_q == TOK_W'(LAST_TOK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tok_q  <= '0;
      half_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      tok_q  <= '0;
      half_q <= 1'b0;
    end else if (busy_q && stb_i) begin
      if (!half_q) begin
        half_q <= 1'b1;
      end else if (last_bit) begin
        busy_q <= 1'b0;
        tok_q  <= '0;
        half_q <= 1'b0;
      end else begin
        tok_q  <= tok_q + TOK_W'(1);
        half_q <= 1'b0;
      end
    end
  end

  assign load_o = start;
  assign busy_o = busy_q;
  assign tok_o  = tok_q;
  assign half_o = half_q;

  // token index stays inside the frame (R5)
  assert_tok_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_q <= TOK_W'(LAST_TOK));

  // outside a frame the sequencer rests at slot zero (R2)
  assert_rest_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (tok_q == '0) && !half_q);
endmodule

// File: rtl/ack_sym_enc.sv
module ack_sym_enc
  import ack_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int TOK_W  = $clog2(ADDR_W + 3),
  localparam int SLOTS = 1 << TOK_W
) (
  input  logic              busy_i,
  input  logic [TOK_W-1:0]  tok_i,
  input  logic              half_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              bit_o
);
  sym_t      tok_code [SLOTS];
  tok_kind_e tok_kind [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g == 0 || g == ADDR_W + 1) begin : g_sel
      assign tok_kind[g] = TK_SELECT;
      assign tok_code[g] = SYM_SELECT;
    end else if (g <= ADDR_W) begin : g_dat
      assign tok_kind[g] = TK_DATA;
      assign tok_code[g] = addr_i[g-1] ? SYM_ONE : SYM_ZERO;
    end else begin : g_idl
      assign tok_kind[g] = TK_IDLE;
      assign tok_code[g] = SYM_IDLE;
    end
  end

  sym_t cur;
  assign cur = tok_code[tok_i];

  // high bit of each token leaves first
  always_comb begin
    if (!busy_i)     bit_o = 1'b1;
    else if (half_i) bit_o = cur[0];
    else             bit_o = cur[1];
  end

  // a data token is never the idle or select pattern (R4)
  always_comb begin
    if (busy_i && tok_kind[tok_i] == TK_DATA)
      assert_data_code_R4: assert (cur == SYM_ONE || cur == SYM_ZERO);
  end
endmodule

// File: rtl/ack_tx.sv
module ack_tx #(
  parameter int ADDR_W = 10,
  localparam int TOK_W = $clog2(ADDR_W + 3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              match_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bit_stb_i,
  output logic              tdo_o,
  output logic              busy_o
);
  logic              load;
  logic              busy;
  logic [TOK_W-1:0]  tok;
  logic              half;
  logic [ADDR_W-1:0] addr_q;

  ack_seq_ctrl #(.ADDR_W(ADDR_W), .TOK_W(TOK_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .match_i(match_i),
    .stb_i  (bit_stb_i),
    .load_o (load),
    .busy_o (busy),
    .tok_o  (tok),
    .half_o (half)
  );

  ack_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .addr_i(addr_i),
    .addr_o(addr_q)
  );

  ack_sym_enc #(.ADDR_W(ADDR_W), .TOK_W(TOK_W)) u_enc (
    .busy_i(busy),
    .tok_i (tok),
    .half_i(half),
    .addr_i(addr_q),
    .bit_o (tdo_o)
  );

  assign busy_o = busy;

  // frame opens with the select high bit right after the match (R3)
  assert_open_select_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !tdo_o);

  assert_open_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(match_i));

  // frame closes on a strobe, after an idle-level bit (R8)
  assert_close_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(bit_stb_i) && $past(tdo_o) && tdo_o);

  // no strobe, no movement (R10)
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !bit_stb_i |=> busy_o && $stable(tdo_o));

  // captured address frozen for the whole frame (R7)
  assert_addr_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(addr_q));
endmodule

// File: tb/tb_ack_tx.sv
module tb_ack_tx;
  localparam int AW = 10;
  localparam int NBITS = 2 * (AW + 3);
  localparam int NV = 6;

  localparam logic [AW-1:0] TV_ADDR [NV] = '{10'h000, 10'h3FF, 10'h001, 10'h200, 10'h2AA, 10'h155};
  localparam logic [AW-1:0] TV_ALT  [NV] = '{10'h3FF, 10'h000, 10'h2F0, 10'h0FF, 10'h155, 10'h2AA};
  localparam int            TV_GAP  [NV] = '{0, 1, 0, 2, 0, 1};
  localparam bit            TV_POKE [NV] = '{0, 0, 1, 0, 1, 0};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          match = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          stb = 1'b0;
  logic          tdo;
  logic          busy;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ack_tx #(.ADDR_W(AW)) dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .match_i  (match),
    .addr_i   (addr),
    .bit_stb_i(stb),
    .tdo_o    (tdo),
    .busy_o   (busy)
  );

  // expected serial bit n from R4/R5/R6
  function automatic logic exp_bit(input logic [AW-1:0] a, input int n);
    int t = n / 2;
    logic [1:0] c;
    if (t == 0 || t == AW + 1) c = 2'b00;
    else if (t <= AW)          c = a[t-1] ? 2'b10 : 2'b01;
    else                       c = 2'b11;
    return (n % 2 == 0) ? c[1] : c[0];
  endfunction

  function automatic string tag_of(input int n);
    int t = n / 2;
    if (n == 0)              return "R3";
    if (t >= 1 && t <= AW)   return "R6";
    if (t == AW + 1)         return "R4";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(busy == 1'b0, req, "busy idle", busy, 0);
    check(tdo == 1'b1, req, "tdo idle", tdo, 1);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [AW-1:0] a, input logic [AW-1:0] alt,
                           input int gap, input bit poke);
    addr  = a;
    match = 1'b1;
    tick();
    match = 1'b0;
    check(busy == 1'b1, "R3", "busy at open", busy, 1);
    check(tdo == exp_bit(a, 0), "R3", "open bit", tdo, exp_bit(a, 0));
    for (int n = 1; n <= NBITS; n++) begin
      for (int g = 0; g < gap; g++) begin
        tick();
        check(tdo == exp_bit(a, n - 1), "R10", "hold tdo", tdo, exp_bit(a, n - 1));
        check(busy == 1'b1, "R10", "hold busy", busy, 1);
      end
      stb = 1'b1;
      if (n == 4) addr = alt;            // R7 disturbance
      if (poke && n == 12) match = 1'b1; // R9 disturbance
      tick();
      stb   = 1'b0;
      match = 1'b0;
      if (n < NBITS) begin
        check(tdo == exp_bit(a, n), tag_of(n), "frame bit", tdo, exp_bit(a, n));
        check(busy == 1'b1, "R8", "busy in frame", busy, 1);
      end else begin
        check(busy == 1'b0, "R8", "busy after end", busy, 0);
        check(tdo == 1'b1, "R8", "tdo after end", tdo, 1);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    tick();
    check_idle("R1");

    // R2: strobes without a match send nothing
    for (int i = 0; i < 8; i++) begin
      stb = i[0];
      addr = AW'(i * 37);
      tick();
      check_idle("R2");
    end
    stb = 1'b0;

    // table walk
    for (int v = 0; v < NV; v++) begin
      run_frame(TV_ADDR[v], TV_ALT[v], TV_GAP[v], TV_POKE[v]);
      for (int i = 0; i < 4; i++) begin
        stb = 1'b1;
        tick();
        check_idle(TV_POKE[v] ? "R9" : "R2");
      end
      stb = 1'b0;
    end

    // R11: back-to-back frames, match right after busy falls
    run_frame(10'h0F3, 10'h0F3, 0, 0);
    run_frame(10'h30C, 10'h0A5, 0, 0);
    tick();
    check_idle("R11");

    // R9: match held during the closing strobe is ignored
    addr  = 10'h1C7;
    match = 1'b1;
    tick();
    match = 1'b0;
    for (int n = 1; n < NBITS; n++) begin
      stb = 1'b1;
      tick();
    end
    match = 1'b1;
    tick();
    stb   = 1'b0;
    match = 1'b0;
    check_idle("R9");
    tick();
    check_idle("R9");

    // R1: reset in mid-frame returns to idle
    addr  = 10'h2B4;
    match = 1'b1;
    tick();
    match = 1'b0;
    stb = 1'b1;
    tick();
    tick();
    stb = 1'b0;
    rst_n = 1'b0;
    #1;
    check_idle("R1");
    tick();
    rst_n = 1'b1;
    tick();
    check_idle("R1");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule